// File: doc/BRIEF.md
# Receive Mailbox Lock Controller

This block sits between a frame matcher and the storage of a small array of receive mailboxes. It keeps the code of every mailbox, a single lock owned by the CPU, and a one-deep holding buffer. When the CPU reads the status word of a receive mailbox that holds data, that mailbox becomes locked. A frame that the matcher routes to a locked mailbox is parked in the holding buffer rather than written. Once the lock is released, the parked frame is copied into the mailbox over a fixed number of cycles. The mailbox shows a busy bit for the whole of that copy.

The lock is released when the CPU reads the free-running timer or reads the status word of another mailbox. Only one mailbox is locked at any time. If a newer frame arrives while an older one is parked, the newer frame replaces it without any indication. Deactivating a mailbox (writing the INACTIVE code) has precedence over everything else. It drops that mailbox's lock, its parked frame, its copy in progress and any match made to it in the same cycle. A compatibility input selects whether a read of an EMPTY mailbox locks it.

Top module: `rx_mbox_lock_ctrl`

## Requirements
- R1: After reset every mailbox code is 4'b0000 with its busy bit low, no lock is held (lock_valid_o=0), the holding buffer is empty (hold_valid_o=0) and mb_wr_en_o is 0.
- R2: A status read (rd_en_i) of a mailbox whose code is a receive code other than INACTIVE (bit 3 = 0, code not 4'b0000) and that is not busy locks it. From the next cycle lock_valid_o=1 and lock_idx_o holds that index. A read of a transmit code (bit 3 = 1) or of INACTIVE never locks.
- R3: With empty_guard_i=1, a read of an EMPTY mailbox (4'b0100) does not lock it. With empty_guard_i=0 the same read locks it.
- R4: A timer read (timer_rd_i), or a status read of a different mailbox, releases the current lock in that cycle. Only one mailbox is locked at a time, so a lockable read of another mailbox moves the lock.
- R5: A match (match_valid_i) to an active receive mailbox that is neither locked nor busy gives, in the next cycle, mb_wr_en_o=1 with that index and frame. The code changes EMPTY to FULL (4'b0010), and FULL or OVERRUN to OVERRUN (4'b0110).
- R6: A match is parked instead of written when its mailbox is locked, is busy, already has a parked frame, or when a copy is completing in that cycle. While it is parked, hold_valid_o=1 and no write occurs.
- R7: A newer match parked while a frame is already parked replaces it. The mailbox code does not change when the frame is replaced, and only the newest frame is later written.
- R8: When the lock on a mailbox with a parked frame is released, bit 0 (busy) of its code is 1 for exactly MOVE_CYCLES cycles. In the cycle after those, mb_wr_en_o carries the parked frame and the code is updated as in R5.
- R9: rd_code_o, valid one cycle after a read (rd_valid_o), shows the mailbox code with the busy bit. A read of a busy mailbox does not lock it. This includes a read made in the same cycle as the release that starts the copy to that mailbox.
- R10: A configuration write of INACTIVE (cfg_code_i[3:1]=0) to a mailbox releases its lock, discards its parked frame or copy in progress, and drops a match made to it in the same cycle. No write follows.
- R11: Matches to a mailbox holding INACTIVE or a transmit code (bit 3 = 1) are dropped without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| empty_guard_i | input | 1 | 1: reads of EMPTY mailboxes do not lock |
| cfg_we_i | input | 1 | CPU writes a mailbox code |
| cfg_idx_i | input | IDX_W | Mailbox written |
| cfg_code_i | input | 4 | Code written (bit 0 ignored) |
| rd_en_i | input | 1 | CPU reads a mailbox status word |
| rd_idx_i | input | IDX_W | Mailbox read |
| timer_rd_i | input | 1 | CPU reads the free-running timer |
| match_valid_i | input | 1 | Matcher delivers a frame |
| match_idx_i | input | IDX_W | Winning mailbox |
| match_frame_i | input | FRAME_W | Frame payload |
| rd_valid_o | output | 1 | rd_code_o valid |
| rd_code_o | output | 4 | Code seen by the read, busy in bit 0 |
| mb_code_o | output | NUM_MB*4 | All mailbox codes, busy in bit 0 of each |
| lock_valid_o | output | 1 | A mailbox is locked |
| lock_idx_o | output | IDX_W | Locked mailbox |
| hold_valid_o | output | 1 | Holding buffer occupied |
| mb_wr_en_o | output | 1 | Write a frame to mailbox storage |
| mb_wr_idx_o | output | IDX_W | Mailbox written |
| mb_wr_frame_o | output | FRAME_W | Frame written |

## Verification
The bench builds the block with eight mailboxes, a 16-bit frame and a four-cycle copy. Eight mailboxes leave room for EMPTY, FULL, transmit and INACTIVE codes side by side, so the lock can be moved between mailboxes and the drop rules can be exercised. The four-cycle copy is long enough that a status read can fall inside the busy window. A behavioural model is compared with the outputs every cycle. Directed sequences cover parked-frame replacement, the release-and-read tie, and deactivation during a lock.

// File: rtl/rxlk_pkg.sv
package rxlk_pkg;
  localparam int CODE_W = 4;
  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CODE_INACTIVE = 4'b0000;
  localparam code_t CODE_EMPTY    = 4'b0100;
  localparam code_t CODE_FULL     = 4'b0010;
  localparam code_t CODE_OVERRUN  = 4'b0110;

  // Deactivation: upper three bits zero (bit 0 is the hardware busy flag)
  function automatic logic code_is_deact(code_t c);
    return c[3:1] == CODE_INACTIVE[3:1];
  endfunction

  // Receive mailbox that takes part in matching
  function automatic logic code_rx_active(code_t c);
    return !c[3] && !code_is_deact(c);
  endfunction

  function automatic logic code_lockable(code_t c, logic guard);
    return code_rx_active(c) && !(guard && c[3:1] == CODE_EMPTY[3:1]);
  endfunction

  function automatic code_t code_after_fill(code_t c);
    return (c[3:1] == CODE_EMPTY[3:1]) ? CODE_FULL : CODE_OVERRUN;
  endfunction
endpackage

// File: rtl/rxlk_lock_track.sv
module rxlk_lock_track #(
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             rd_lockable_i,
  input  logic             timer_rd_i,
  input  logic             deact_i,
  input  logic [IDX_W-1:0] deact_idx_i,
  output logic             lock_v_o,
  output logic [IDX_W-1:0] lock_idx_o,
  output logic             keep_o,
  output logic             nx_v_o,
  output logic [IDX_W-1:0] nx_idx_o
);
  logic             lock_v_q;
  logic [IDX_W-1:0] lock_idx_q;
  logic             release_ev;

  assign release_ev = lock_v_q && (timer_rd_i
                    || (rd_en_i && rd_idx_i != lock_idx_q)
                    || (deact_i && deact_idx_i == lock_idx_q));
  assign keep_o = lock_v_q && !release_ev;

  always_comb begin
    if (rd_lockable_i) begin
      nx_v_o   = 1'b1;
      nx_idx_o = rd_idx_i;
    end else begin
      nx_v_o   = keep_o;
      nx_idx_o = lock_idx_q;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      lock_v_q   <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_v_q   <= nx_v_o;
      lock_idx_q <= nx_idx_o;
    end
  end

  assign lock_v_o   = lock_v_q;
  assign lock_idx_o = lock_idx_q;

  // R10: a deactivated mailbox is never locked in the following cycle
  p_deact_clears_lock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deact_i |=> !(lock_v_q && lock_idx_q == $past(deact_idx_i)));
  // R4: a timer read with no new lock leaves nothing locked
  p_timer_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timer_rd_i && !rd_lockable_i) |=> !lock_v_q);
endmodule

// File: rtl/rxlk_hold_buf.sv
module rxlk_hold_buf #(
  parameter int IDX_W   = 3,
  parameter int FRAME_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               park_i,
  input  logic [IDX_W-1:0]   park_idx_i,
  input  logic [FRAME_W-1:0] park_frame_i,
  input  logic               drain_i,
  input  logic               deact_i,
  input  logic [IDX_W-1:0]   deact_idx_i,
  output logic               hold_v_o,
  output logic [IDX_W-1:0]   hold_idx_o,
  output logic [FRAME_W-1:0] hold_frame_o,
  output logic               cancel_o
);
  logic               hold_v_q;
  logic [IDX_W-1:0]   hold_idx_q;
  logic [FRAME_W-1:0] hold_frame_q;

  assign cancel_o = hold_v_q && deact_i && deact_idx_i == hold_idx_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      hold_v_q     <= 1'b0;
      hold_idx_q   <= '0;
      hold_frame_q <= '0;
    end else if (park_i) begin
      // newest frame silently replaces the parked one
      hold_v_q     <= 1'b1;
      hold_idx_q   <= park_idx_i;
      hold_frame_q <= park_frame_i;
    end else if (drain_i || cancel_o) begin
      hold_v_q     <= 1'b0;
    end
  end

  assign hold_v_o     = hold_v_q;
  assign hold_idx_o   = hold_idx_q;
  assign hold_frame_o = hold_frame_q;

  // R6: an occupied buffer that nothing touches keeps its frame
  p_hold_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_v_q && !park_i && !drain_i && !cancel_o) |=> (hold_v_q && $stable(hold_frame_q)));
  // R7: a park always leaves the newest frame in the buffer
  p_park_newest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    park_i |=> (hold_v_q && hold_frame_q == $past(park_frame_i)));
endmodule

// File: rtl/rxlk_move_eng.sv
module rxlk_move_eng #(
  parameter int IDX_W       = 3,
  parameter int FRAME_W     = 32,
  parameter int MOVE_CYCLES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [IDX_W-1:0]   start_idx_i,
  input  logic [FRAME_W-1:0] start_frame_i,
  input  logic               deact_i,
  input  logic [IDX_W-1:0]   deact_idx_i,
  output logic               active_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               fin_o
);
  localparam int CNT_W = (MOVE_CYCLES > 1) ? $clog2(MOVE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MOVE_CYCLES - 1);

  logic               active_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               cancel;

  assign cancel = active_q && deact_i && deact_idx_i == idx_q;
  assign fin_o  = active_q && cnt_q == CNT_LAST && !cancel;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      frame_q  <= '0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= start_idx_i;
      frame_q  <= start_frame_i;
      cnt_q    <= '0;
    end else if (cancel || fin_o) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign idx_o    = idx_q;
  assign frame_o  = frame_q;

  // R8: a copy is only started when the engine is idle
  p_start_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q);
  // R10: deactivating the target aborts the copy
  p_cancel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel |=> !active_q);
endmodule

// File: rtl/rx_mbox_lock_ctrl.sv
module rx_mbox_lock_ctrl
  import rxlk_pkg::*;
#(
  parameter int NUM_MB      = 8,
  parameter int FRAME_W     = 32,
  parameter int MOVE_CYCLES = 4,
  localparam int IDX_W      = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     empty_guard_i,
  input  logic                     cfg_we_i,
  input  logic [IDX_W-1:0]         cfg_idx_i,
  input  logic [3:0]               cfg_code_i,
  input  logic                     rd_en_i,
  input  logic [IDX_W-1:0]         rd_idx_i,
  input  logic                     timer_rd_i,
  input  logic                     match_valid_i,
  input  logic [IDX_W-1:0]         match_idx_i,
  input  logic [FRAME_W-1:0]       match_frame_i,
  output logic                     rd_valid_o,
  output logic [3:0]               rd_code_o,
  output logic [NUM_MB*4-1:0]      mb_code_o,
  output logic                     lock_valid_o,
  output logic [IDX_W-1:0]         lock_idx_o,
  output logic                     hold_valid_o,
  output logic                     mb_wr_en_o,
  output logic [IDX_W-1:0]         mb_wr_idx_o,
  output logic [FRAME_W-1:0]       mb_wr_frame_o
);
  code_t              code_q [NUM_MB];
  logic [NUM_MB-1:0]  busy_now;
  logic [NUM_MB-1:0]  busy_q;

  // named internal events
  logic               deact;
  logic               lock_keep, lock_nx_v;
  logic [IDX_W-1:0]   lock_nx_idx;
  logic               rd_lockable;
  logic               hold_v, hold_cancel;
  logic [IDX_W-1:0]   hold_idx;
  logic [FRAME_W-1:0] hold_frame;
  logic               move_go, mv_active, mv_fin;
  logic [IDX_W-1:0]   mv_idx;
  logic [FRAME_W-1:0] mv_frame;
  logic               match_ok, park, direct;

  assign deact = cfg_we_i && code_is_deact(cfg_code_i);

  assign move_go = hold_v && !hold_cancel && !mv_active
                && !(lock_keep && lock_idx_o == hold_idx);

  for (genvar i = 0; i < NUM_MB; i++) begin : g_busy
    assign busy_q[i]   = mv_active && mv_idx == IDX_W'(i);
    assign busy_now[i] = busy_q[i] || (move_go && hold_idx == IDX_W'(i));
    assign mb_code_o[i*4 +: 4] = {code_q[i][3:1], busy_q[i]};
  end

  assign rd_lockable = rd_en_i && !busy_now[rd_idx_i]
                    && !(deact && cfg_idx_i == rd_idx_i)
                    && code_lockable(code_q[rd_idx_i], empty_guard_i);

  rxlk_lock_track #(.IDX_W(IDX_W)) u_lock (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_en_i      (rd_en_i),
    .rd_idx_i     (rd_idx_i),
    .rd_lockable_i(rd_lockable),
    .timer_rd_i   (timer_rd_i),
    .deact_i      (deact),
    .deact_idx_i  (cfg_idx_i),
    .lock_v_o     (lock_valid_o),
    .lock_idx_o   (lock_idx_o),
    .keep_o       (lock_keep),
    .nx_v_o       (lock_nx_v),
    .nx_idx_o     (lock_nx_idx)
  );

  assign match_ok = match_valid_i && code_rx_active(code_q[match_idx_i])
                 && !(deact && cfg_idx_i == match_idx_i);
  assign park   = match_ok && ((lock_nx_v && lock_nx_idx == match_idx_i)
                 || busy_now[match_idx_i]
                 || (hold_v && hold_idx == match_idx_i)
                 || mv_fin);
  assign direct = match_ok && !park;

  rxlk_hold_buf #(.IDX_W(IDX_W), .FRAME_W(FRAME_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .park_i      (park),
    .park_idx_i  (match_idx_i),
    .park_frame_i(match_frame_i),
    .drain_i     (move_go),
    .deact_i     (deact),
    .deact_idx_i (cfg_idx_i),
    .hold_v_o    (hold_v),
    .hold_idx_o  (hold_idx),
    .hold_frame_o(hold_frame),
    .cancel_o    (hold_cancel)
  );

  rxlk_move_eng #(.IDX_W(IDX_W), .FRAME_W(FRAME_W), .MOVE_CYCLES(MOVE_CYCLES)) u_move (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (move_go),
    .start_idx_i  (hold_idx),
    .start_frame_i(hold_frame),
    .deact_i      (deact),
    .deact_idx_i  (cfg_idx_i),
    .active_o     (mv_active),
    .idx_o        (mv_idx),
    .frame_o      (mv_frame),
    .fin_o        (mv_fin)
  );

  assign hold_valid_o = hold_v;

  // mailbox codes: CPU write wins over a delivery in the same cycle
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < NUM_MB; i++) begin
      if (!rst_ni) begin
        code_q[i] <= CODE_INACTIVE;
      end else if (cfg_we_i && cfg_idx_i == IDX_W'(i)) begin
        code_q[i] <= {cfg_code_i[3:1], 1'b0};
      end else if ((direct && match_idx_i == IDX_W'(i)) || (mv_fin && mv_idx == IDX_W'(i))) begin
        code_q[i] <= code_after_fill(code_q[i]);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mb_wr_en_o    <= 1'b0;
      mb_wr_idx_o   <= '0;
      mb_wr_frame_o <= '0;
      rd_valid_o    <= 1'b0;
      rd_code_o     <= '0;
    end else begin
      mb_wr_en_o    <= direct || mv_fin;
      mb_wr_idx_o   <= direct ? match_idx_i : mv_idx;
      mb_wr_frame_o <= direct ? match_frame_i : mv_frame;
      rd_valid_o    <= rd_en_i;
      rd_code_o     <= {code_q[rd_idx_i][3:1], busy_now[rd_idx_i]};
    end
  end

  // R8: at most one mailbox is busy at a time
  p_busy_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(busy_q));
  // R6: storage is never written for the mailbox that is locked
  p_no_write_locked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_wr_en_o |-> !(lock_valid_o && lock_idx_o == mb_wr_idx_o));
  // R9: a read that finds the mailbox busy does not lock it
  p_busy_no_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && busy_now[rd_idx_i]) |=> !(lock_valid_o && lock_idx_o == $past(rd_idx_i)));
  // R5: a match taken directly is written in the next cycle
  p_direct_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    direct |=> (mb_wr_en_o && mb_wr_idx_o == $past(match_idx_i)));
  // R11: matches to inactive or transmit mailboxes cause no write
  p_drop_inactive_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_valid_i && !code_rx_active(code_q[match_idx_i]) && !mv_fin) |=> !mb_wr_en_o);
endmodule

// File: tb/rx_mbox_lock_ctrl_tb_top.sv
module rx_mbox_lock_ctrl_tb_top;
  localparam int NMB = 8;
  localparam int FW  = 16;
  localparam int MV  = 4;
  localparam int IW  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          guard = 1'b1;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [3:0]    cfg_code = '0;
  logic          rd_en = 1'b0;
  logic [IW-1:0] rd_idx = '0;
  logic          timer_rd = 1'b0;
  logic          m_valid = 1'b0;
  logic [IW-1:0] m_idx = '0;
  logic [FW-1:0] m_frame = '0;
  logic          rd_valid;
  logic [3:0]    rd_code;
  logic [NMB*4-1:0] mb_code;
  logic          lock_v;
  logic [IW-1:0] lock_idx;
  logic          hold_v;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [FW-1:0] wr_frame;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_mbox_lock_ctrl #(.NUM_MB(NMB), .FRAME_W(FW), .MOVE_CYCLES(MV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .empty_guard_i(guard),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_code_i(cfg_code),
    .rd_en_i(rd_en), .rd_idx_i(rd_idx), .timer_rd_i(timer_rd),
    .match_valid_i(m_valid), .match_idx_i(m_idx), .match_frame_i(m_frame),
    .rd_valid_o(rd_valid), .rd_code_o(rd_code), .mb_code_o(mb_code),
    .lock_valid_o(lock_v), .lock_idx_o(lock_idx), .hold_valid_o(hold_v),
    .mb_wr_en_o(wr_en), .mb_wr_idx_o(wr_idx), .mb_wr_frame_o(wr_frame)
  );

  // ---------------- behavioural reference model ----------------
  int mcode [NMB];
  bit lk; int lk_at;
  bit pk; int pk_at; int pk_fr;
  bit cp; int cp_at; int cp_fr; int cp_n;
  bit ow; int ow_at; int ow_fr;
  int orc;

  function automatic bit is_rx(int c);
    return c != 0 && c < 8;
  endfunction

  function automatic int filled(int c);
    return (c == 4) ? 2 : 6;
  endfunction

  task automatic model_step();
    bit kill, stays, pk_gone, cp_gone, cp_done, go, can_lock, ok, hold_it, straight;
    bit nlk; int nlk_at;
    int tgt;
    kill    = cfg_we && (cfg_code >> 1) == 0;
    stays   = lk && !(timer_rd || (rd_en && int'(rd_idx) != lk_at) || (kill && int'(cfg_idx) == lk_at));
    pk_gone = pk && kill && int'(cfg_idx) == pk_at;
    cp_gone = cp && kill && int'(cfg_idx) == cp_at;
    cp_done = cp && cp_n == MV - 1 && !cp_gone;
    go      = pk && !pk_gone && !cp && !(stays && lk_at == pk_at);
    can_lock = rd_en && !((cp && cp_at == int'(rd_idx)) || (go && pk_at == int'(rd_idx)))
               && !(kill && int'(cfg_idx) == int'(rd_idx)) && is_rx(mcode[rd_idx])
               && !(guard && mcode[rd_idx] == 4);
    if (can_lock) begin nlk = 1; nlk_at = int'(rd_idx); end
    else begin nlk = stays; nlk_at = lk_at; end
    tgt = int'(m_idx);
    ok = m_valid && is_rx(mcode[tgt]) && !(kill && int'(cfg_idx) == tgt);
    hold_it = ok && ((nlk && nlk_at == tgt) || (cp && cp_at == tgt) || (go && pk_at == tgt)
              || (pk && pk_at == tgt) || cp_done);
    straight = ok && !hold_it;
    // outputs registered at this edge
    orc = ((mcode[rd_idx] >> 1) << 1) | ((cp && cp_at == int'(rd_idx)) || (go && pk_at == int'(rd_idx)) ? 1 : 0);
    ow = straight || cp_done;
    ow_at = straight ? tgt : cp_at;
    ow_fr = straight ? int'(m_frame) : cp_fr;
    // mailbox codes
    for (int k = 0; k < NMB; k++) begin
      if (cfg_we && int'(cfg_idx) == k) mcode[k] = int'(cfg_code) & 14;
      else if ((straight && tgt == k) || (cp_done && cp_at == k)) mcode[k] = filled(mcode[k]);
    end
    // copy engine
    if (go) begin cp = 1; cp_at = pk_at; cp_fr = pk_fr; cp_n = 0; end
    else if (cp_gone || cp_done) cp = 0;
    else if (cp) cp_n++;
    // holding buffer
    if (hold_it) begin pk = 1; pk_at = tgt; pk_fr = int'(m_frame); end
    else if (go || pk_gone) pk = 0;
    lk = nlk; lk_at = nlk_at;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NMB; k++) mcode[k] = 0;
      lk = 0; lk_at = 0; pk = 0; pk_at = 0; pk_fr = 0;
      cp = 0; cp_at = 0; cp_fr = 0; cp_n = 0;
      ow = 0; ow_at = 0; ow_fr = 0; orc = 0;
    end else begin
      model_step();
    end
  end

  // cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      for (int k = 0; k < NMB; k++) begin
        if (int'(mb_code[k*4 +: 4]) != (mcode[k] | ((cp && cp_at == k) ? 1 : 0))) begin
          errors++;
          $display("FAIL model R5/R8 mb%0d code act %b exp %b", k, mb_code[k*4 +: 4],
                   4'(mcode[k] | ((cp && cp_at == k) ? 1 : 0)));
        end
      end
      if (lock_v != lk || (lk && int'(lock_idx) != lk_at)) begin
        errors++;
        $display("FAIL model R4 lock act %0b/%0d exp %0b/%0d", lock_v, lock_idx, lk, lk_at);
      end
      if (hold_v != pk) begin
        errors++;
        $display("FAIL model R6 hold act %0b exp %0b", hold_v, pk);
      end
      if (wr_en != ow || (ow && (int'(wr_idx) != ow_at || int'(wr_frame) != ow_fr))) begin
        errors++;
        $display("FAIL model R5 write act %0b/%0d/%h exp %0b/%0d/%h", wr_en, wr_idx, wr_frame, ow, ow_at, ow_fr);
      end
      if (rd_valid && int'(rd_code) != orc) begin
        errors++;
        $display("FAIL model R9 rd_code act %b exp %b", rd_code, 4'(orc));
      end
    end
  end

  // ---------------- directed checks ----------------
  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act %0d exp %0d", tag, act, exp);
    end
  endtask

  function automatic int code_of(int k);
    return int'(mb_code[k*4 +: 4]);
  endfunction

  task automatic tick();
    @(negedge clk);
    cfg_we = 0; rd_en = 0; timer_rd = 0; m_valid = 0;
  endtask

  task automatic do_cfg(int k, int c);
    cfg_we = 1; cfg_idx = IW'(k); cfg_code = 4'(c); tick();
  endtask

  task automatic do_rd(int k);
    rd_en = 1; rd_idx = IW'(k); tick();
  endtask

  task automatic do_match(int k, int f);
    m_valid = 1; m_idx = IW'(k); m_frame = FW'(f); tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int k = 0; k < NMB; k++) chk("R1 code", code_of(k), 0);
    chk("R1 lock", int'(lock_v), 0);
    chk("R1 hold", int'(hold_v), 0);
    chk("R1 wr", int'(wr_en), 0);

    for (int k = 0; k < 6; k++) do_cfg(k, 4);
    do_cfg(6, 8);

    // R5 direct delivery
    do_match(2, 16'hA001);
    chk("R5 wr", int'(wr_en), 1);
    chk("R5 idx", int'(wr_idx), 2);
    chk("R5 frame", int'(wr_frame), 16'hA001);
    chk("R5 full", code_of(2), 2);
    do_match(2, 16'hA002);
    chk("R5 overrun", code_of(2), 6);

    // R3 guard on: EMPTY read does not lock
    guard = 1;
    do_rd(3);
    chk("R3 no lock", int'(lock_v), 0);
    chk("R9 rd_code empty", int'(rd_code), 4);
    // R2 transmit never locks
    do_rd(6);
    chk("R2 tx no lock", int'(lock_v), 0);
    // R2 full mailbox locks
    do_rd(2);
    chk("R2 lock", int'(lock_v), 1);
    chk("R2 lock idx", int'(lock_idx), 2);

    // R6 park, R7 replace
    do_match(2, 16'hB001);
    chk("R6 no wr", int'(wr_en), 0);
    chk("R6 hold", int'(hold_v), 1);
    do_match(2, 16'hB002);
    chk("R7 no wr", int'(wr_en), 0);
    chk("R7 code unchanged", code_of(2), 6);

    // R4 timer release, R8 busy window
    timer_rd = 1; tick();
    chk("R4 released", int'(lock_v), 0);
    chk("R8 busy c1", code_of(2), 7);
    for (int c = 2; c <= MV; c++) begin
      tick();
      chk("R8 busy", code_of(2) & 1, 1);
      chk("R8 no wr yet", int'(wr_en), 0);
    end
    tick();
    chk("R8 wr", int'(wr_en), 1);
    chk("R7 newest frame", int'(wr_frame), 16'hB002);
    chk("R8 busy off", code_of(2), 6);

    // R3 guard off: EMPTY read locks; R4 lock moves
    guard = 0;
    do_rd(3);
    chk("R3 empty lock", int'(lock_v), 1);
    chk("R3 empty lock idx", int'(lock_idx), 3);
    do_rd(4);
    chk("R4 lock moved", int'(lock_idx), 4);
    do_match(4, 16'h0C0C);
    chk("R6 hold2", int'(hold_v), 1);

    // R10 deactivation of the locked mailbox
    do_cfg(4, 0);
    chk("R10 lock cleared", int'(lock_v), 0);
    chk("R10 hold cleared", int'(hold_v), 0);
    for (int c = 0; c < MV + 2; c++) begin
      tick();
      chk("R10 no wr", int'(wr_en), 0);
    end
    cfg_we = 1; cfg_idx = 5; cfg_code = 0;
    m_valid = 1; m_idx = 5; m_frame = 16'h0505;
    tick();
    chk("R10 same-cycle match dropped", int'(wr_en), 0);

    // R11 inactive and transmit targets
    do_match(7, 16'h0707);
    chk("R11 inactive drop", int'(wr_en), 0);
    do_match(6, 16'h0606);
    chk("R11 tx drop", int'(wr_en), 0);
    chk("R11 tx code", code_of(6), 8);

    // R9 release and read in the same cycle
    guard = 1;
    do_match(1, 16'h0D00);
    chk("R5 mb1 full", code_of(1), 2);
    do_rd(1);
    chk("R2 lock mb1", int'(lock_idx), 1);
    do_match(1, 16'h0D01);
    timer_rd = 1; rd_en = 1; rd_idx = 1; tick();
    chk("R9 tie busy seen", int'(rd_code), 3);
    chk("R9 tie no lock", int'(lock_v), 0);
    do_rd(1);
    chk("R9 busy read", int'(rd_code), 3);
    chk("R9 busy no lock", int'(lock_v), 0);
    tick();
    chk("R8 no wr c3", int'(wr_en), 0);
    tick();
    chk("R8 no wr c4", int'(wr_en), 0);
    tick();
    chk("R8 wr mb1", int'(wr_en), 1);
    chk("R8 wr mb1 frame", int'(wr_frame), 16'h0D01);
    chk("R5 mb1 overrun", code_of(1), 6);

    repeat (4) tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog R1 act 0 exp 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule